// File: doc/BRIEF.md
# T1 Transmit Bit Multiplexer

This block assembles the outgoing T1 line bit stream at one bit per transmit clock. In every bit period it takes one bit from one of four places: the serial payload input, the link input, the robbed-bit signaling input, or its own framing and CRC-6 generator. Strobes from a companion timing generator decide which. `fbit_pos` marks the frame-bit period, `sig_pos` marks a signaling bit slot, and `frame_idx` gives the frame number within the superframe. Configuration inputs choose the superframe format (24-frame extended or 12-frame), where framing and S-bits come from, whether robbed-bit signaling is inserted, and the rail format.

None of the data inputs is stored ahead of use, so each one must hold the right bit at the edge where it is taken. The rising edge of `clk` is the sampling edge: the core clock is the transmit clock inverted, so this edge is the transmit clock's falling edge. The chosen bit goes through a shift pipeline cleared at reset. It then reaches a rail formatter that drives either alternating positive/negative rails or NRZ on the positive rail only. Line coding, host access and pin-strap decoding belong to other blocks.

Top module: `t1_tx_mux`

## Requirements
- R1: After reset is released, both rails stay low through the first 10 rising edges. This holds because the latency pipeline and the rail register start at zero.
- R2: The bit selected at rising edge k appears on the rails just after rising edge k+10. This is 10 clock cycles later, with nothing added and nothing dropped.
- R3: In a bit period that is neither the frame bit nor a signaling slot, the selected bit is `ser_data`.
- R4: With `cfg_rbs_en`=1, a signaling slot (`sig_pos`=1, `fbit_pos`=0) takes `sig_data`. With `cfg_rbs_en`=0, `sig_data` has no effect and the slot carries `ser_data`.
- R5: In extended format (`cfg_esf`=1), frame bits with an even `frame_idx` are data link bits. They always come from `link_data`, whatever the other settings are.
- R6: In extended format, the frame bits with `frame_idx` 3, 7, 11, 15, 19 and 23 carry the alignment pattern 0, 0, 1, 0, 1, 1, in that order. When `cfg_ext_frame`=1 they come from `ser_data` instead.
- R7: In extended format, the frame bits with `frame_idx` 1, 5, 9, 13, 17 and 21 carry the CRC-6 of the previous superframe, most significant bit first. When `cfg_ext_frame`=1 they come from `ser_data` instead. The CRC uses polynomial x^6+x+1 and starts at zero. It runs serially over every selected bit of the superframe in line order, with each frame bit counted as 1. A superframe starts at the frame bit with `frame_idx`=0. The value held before the first boundary is zero.
- R8: In 12-frame format (`cfg_esf`=0), the frame bits with `frame_idx` 0, 2, 4, 6, 8 and 10 carry 1, 0, 1, 0, 1, 0. When `cfg_ext_frame`=1 they come from `ser_data` instead.
- R9: In 12-frame format, the frame bits with `frame_idx` 1, 3, 5, 7, 9 and 11 are S-bits carrying 0, 0, 1, 1, 1, 0. When `cfg_ext_sbit`=1 they come from `link_data` instead.
- R10: With `cfg_nrz`=0 (dual-unipolar), a 0 leaves both rails low. Successive 1s go alternately to `tx_pos` and `tx_neg`, and the first 1 after reset goes to `tx_pos`. Both rails are never high together.
- R11: With `cfg_nrz`=1, `tx_pos` carries the bit and `tx_neg` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; rising edge is the sampling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial payload, and external framing/CRC bits |
| link_data | input | 1 | Data link bits and external S-bits |
| sig_data | input | 1 | Robbed-bit signaling input |
| fbit_pos | input | 1 | Strobe: current bit is the frame bit |
| sig_pos | input | 1 | Strobe: current bit is a signaling slot |
| frame_idx | input | 5 | Frame number within the superframe (0-23 or 0-11) |
| cfg_esf | input | 1 | 1 = 24-frame extended format, 0 = 12-frame format |
| cfg_ext_frame | input | 1 | 1 = framing and CRC bits taken from ser_data |
| cfg_ext_sbit | input | 1 | 1 = S-bits taken from link_data (12-frame format) |
| cfg_rbs_en | input | 1 | Enables robbed-bit signaling insertion |
| cfg_nrz | input | 1 | 1 = NRZ on positive rail, 0 = dual-unipolar |
| tx_pos | output | 1 | Positive rail |
| tx_neg | output | 1 | Negative rail |

## Verification
A reference timing model walks whole superframes in both formats. The bench uses random payload, link and signaling bits, so every frame-bit class and signaling slot is exercised with bits that differ from the other sources. A wrong source choice or a wrong pattern entry therefore shows up at once. Running the extended format over more than two superframes separates a CRC that holds the previous superframe's remainder from one that is zero, stale or bit-reversed. Runs with signaling disabled but `sig_data` still toggling, and with external framing and S-bits, confirm which source each setting selects. A segment of all-ones payload tells strict rail alternation apart from a formatter that repeats a rail.

// File: rtl/t1_tx_mux.sv
`timescale 1ns/1ps
module t1_tx_mux #(
  parameter int LATENCY = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_data,
  input  logic       link_data,
  input  logic       sig_data,
  input  logic       fbit_pos,
  input  logic       sig_pos,
  input  logic [4:0] frame_idx,
  input  logic       cfg_esf,
  input  logic       cfg_ext_frame,
  input  logic       cfg_ext_sbit,
  input  logic       cfg_rbs_en,
  input  logic       cfg_nrz,
  output logic       tx_pos,
  output logic       tx_neg
);

  localparam int CRC_W = 6;
  localparam logic [7:0] ALIGN_PAT = 8'b0011_0100;
  localparam logic [7:0] FT_PAT    = 8'b0001_0101;
  localparam logic [7:0] S_PAT     = 8'b0001_1100;

  logic [CRC_W-1:0]   crc_run, crc_hold;
  logic [LATENCY-1:0] pipe;
  logic               mark;
  logic               gen_bit, frame_bit, pick;

  wire [2:0] quad    = frame_idx[4:2];
  wire [3:0] pair    = frame_idx[4:1];
  wire       quad_ok = quad < 3'd6;
  wire       pair_ok = pair < 4'd6;
  wire       sf_edge = fbit_pos && (frame_idx == 5'd0);

  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] r, logic b);
    logic fb;
    fb = b ^ r[CRC_W-1];
    return {r[CRC_W-2:0], 1'b0} ^ {{(CRC_W-2){1'b0}}, fb, fb};
  endfunction

  always_comb begin
    gen_bit = 1'b0;
    if (cfg_esf) begin
      if (frame_idx[1:0] == 2'b11)
        gen_bit = quad_ok ? ALIGN_PAT[quad] : 1'b0;
      else if (frame_idx[1:0] == 2'b01)
        gen_bit = quad_ok ? crc_hold[3'd5 - quad] : 1'b0;
    end else if (pair_ok) begin
      gen_bit = frame_idx[0] ? S_PAT[pair[2:0]] : FT_PAT[pair[2:0]];
    end
  end

  always_comb begin
    if (cfg_esf)
      frame_bit = !frame_idx[0] ? link_data : (cfg_ext_frame ? ser_data : gen_bit);
    else if (!frame_idx[0])
      frame_bit = cfg_ext_frame ? ser_data : gen_bit;
    else
      frame_bit = cfg_ext_sbit ? link_data : gen_bit;
  end

  assign pick = fbit_pos ? frame_bit :
                (cfg_rbs_en && sig_pos) ? sig_data : ser_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_run  <= '0;
      crc_hold <= '0;
    end else if (sf_edge) begin
      crc_hold <= crc_run;
      crc_run  <= crc_step('0, 1'b1);
    end else begin
      crc_run  <= crc_step(crc_run, fbit_pos ? 1'b1 : pick);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[LATENCY-2:0], pick};
  end

  wire line_bit = pipe[LATENCY-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pos <= 1'b0;
      tx_neg <= 1'b0;
      mark   <= 1'b0;
    end else if (cfg_nrz) begin
      tx_pos <= line_bit;
      tx_neg <= 1'b0;
    end else begin
      tx_pos <= line_bit & ~mark;
      tx_neg <= line_bit & mark;
      mark   <= mark ^ line_bit;
    end
  end

endmodule

// File: rtl/t1_tx_mux_chk.sv
`timescale 1ns/1ps
module t1_tx_mux_chk #(
  parameter int LATENCY = 10
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_nrz,
  input logic tx_pos,
  input logic tx_neg
);
  localparam int CW = $clog2(LATENCY + 2);

  logic [CW-1:0] since_rst;
  logic          nrz_q, want_neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      nrz_q     <= 1'b0;
      want_neg  <= 1'b0;
    end else begin
      if (since_rst <= CW'(LATENCY)) since_rst <= since_rst + 1'b1;
      nrz_q <= cfg_nrz;
      if (!nrz_q && (tx_pos || tx_neg)) want_neg <= tx_pos;
    end
  end

  AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst <= CW'(LATENCY)) |-> (!tx_pos && !tx_neg)); // R1

  AST_RAILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_pos && tx_neg)); // R10

  AST_RAILS_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nrz_q && (tx_pos || tx_neg)) |-> (tx_neg == want_neg)); // R10

  AST_NRZ_NEG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_nrz |=> !tx_neg); // R11

endmodule

bind t1_tx_mux t1_tx_mux_chk #(.LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_nrz(cfg_nrz), .tx_pos(tx_pos), .tx_neg(tx_neg)
);

// File: tb/tb_t1_tx_mux.sv
`timescale 1ns/1ps
module tb_t1_tx_mux;
  localparam int LAT = 10;
  localparam int BITS_PER_FRAME = 193;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic ser_data = 0, link_data = 0, sig_data = 0, fbit_pos = 0, sig_pos = 0;
  logic [4:0] frame_idx = '0;
  logic cfg_esf = 0, cfg_ext_frame = 0, cfg_ext_sbit = 0, cfg_rbs_en = 0, cfg_nrz = 0;
  logic tx_pos, tx_neg;

  t1_tx_mux #(.LATENCY(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .link_data(link_data),
    .sig_data(sig_data), .fbit_pos(fbit_pos), .sig_pos(sig_pos),
    .frame_idx(frame_idx), .cfg_esf(cfg_esf), .cfg_ext_frame(cfg_ext_frame),
    .cfg_ext_sbit(cfg_ext_sbit), .cfg_rbs_en(cfg_rbs_en), .cfg_nrz(cfg_nrz),
    .tx_pos(tx_pos), .tx_neg(tx_neg)
  );

  typedef struct { logic p; logic n; string req; } exp_t;
  exp_t exp_q[$];

  int checks = 0, fails = 0, edge_n = 0;
  int bc = 0, fi = 0;
  logic [5:0] m_crc = '0, m_hold = '0;
  logic m_mark = 1'b0;
  int align_seq[6] = '{0, 0, 1, 0, 1, 1};
  int ft_seq[6]    = '{1, 0, 1, 0, 1, 0};
  int s_seq[6]     = '{0, 0, 1, 1, 1, 0};

  function automatic logic [5:0] crc_ref(logic [5:0] r, logic b);
    logic top;
    top = r[5] ^ b;
    r = r << 1;
    if (top) r = r ^ 6'h03;
    return r;
  endfunction

  task automatic check(input logic ap, input logic an, input logic ep, input logic en, input string req);
    checks++;
    if (ap !== ep || an !== en) begin
      fails++;
      $display("FAIL %s at edge %0d: rails pos=%b neg=%b, expected pos=%b neg=%b", req, edge_n, ap, an, ep, en);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) edge_n = 0;
    else begin
      edge_n++;
      #5;
      if (edge_n <= LAT) check(tx_pos, tx_neg, 1'b0, 1'b0, "R1");
      else if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: no expected bit queued, actual pos=%b neg=%b, expected queued item", tx_pos, tx_neg);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(tx_pos, tx_neg, e.p, e.n, e.req);
      end
    end
  end

  task automatic drive_cycle(input int data_mode);
    logic s, l, g, b;
    string tag;
    int nfr;
    nfr = cfg_esf ? 24 : 12;
    s = (data_mode == 1) ? 1'b1 : 1'($urandom % 2);
    l = 1'($urandom % 2);
    g = 1'($urandom % 2);
    ser_data = s; link_data = l; sig_data = g;
    fbit_pos = (bc == 0);
    frame_idx = 5'(fi);
    sig_pos = (bc != 0) && (bc % 8 == 0) && (fi % 6 == 5);
    if (bc == 0) begin
      if (cfg_esf) begin
        if (fi % 2 == 0) begin b = l; tag = "R5"; end
        else if (fi % 4 == 1) begin b = cfg_ext_frame ? s : m_hold[5 - fi / 4]; tag = "R7"; end
        else begin b = cfg_ext_frame ? s : 1'(align_seq[fi / 4]); tag = "R6"; end
      end else begin
        if (fi % 2 == 0) begin b = cfg_ext_frame ? s : 1'(ft_seq[fi / 2]); tag = "R8"; end
        else begin b = cfg_ext_sbit ? l : 1'(s_seq[fi / 2]); tag = "R9"; end
      end
    end else if (sig_pos) begin
      b = cfg_rbs_en ? g : s; tag = "R4";
    end else begin
      b = s; tag = "R3";
    end
    if (bc == 0 && fi == 0) begin
      m_hold = m_crc;
      m_crc = crc_ref(6'd0, 1'b1);
    end else m_crc = crc_ref(m_crc, (bc == 0) ? 1'b1 : b);
    if (cfg_nrz) exp_q.push_back('{b, 1'b0, {tag, " R2 R11"}});
    else begin
      exp_q.push_back('{b & ~m_mark, b & m_mark, {tag, " R2 R10"}});
      m_mark = m_mark ^ b;
    end
    bc++;
    if (bc == BITS_PER_FRAME) begin
      bc = 0;
      fi = (fi + 1) % nfr;
    end
  endtask

  task automatic run_seg(input logic esf, input logic ext_f, input logic ext_s,
                         input logic rbs, input logic nrz, input int data_mode, input int ncyc);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_esf = esf; cfg_ext_frame = ext_f; cfg_ext_sbit = ext_s;
    cfg_rbs_en = rbs; cfg_nrz = nrz;
    repeat (3) @(negedge clk);
    exp_q.delete();
    m_crc = '0; m_hold = '0; m_mark = 1'b0; bc = 0; fi = 0;
    rst_n = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      drive_cycle(data_mode);
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(150000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual hung, expected completion");
    summary();
  end

  initial begin
    run_seg(1, 0, 0, 1, 0, 0, 4632 * 2 + 1200); // R5 R6 R7 R4 R10
    run_seg(1, 1, 0, 0, 1, 0, 4632 + 600);      // R6 R7 external, R4 ignored, R11
    run_seg(0, 0, 0, 1, 0, 0, 2316 * 2 + 300);  // R8 R9 internal, R3
    run_seg(0, 1, 1, 0, 1, 0, 2316 + 300);      // R8 R9 external, R11
    run_seg(0, 0, 0, 0, 0, 1, 1500);            // R10 alternation on all ones
    summary();
  end

endmodule